// File: doc/BRIEF.md
# SPI Slave with Select Framing

This block is the serial-peripheral slave end of a four-wire link. It runs on a fast system clock and treats the serial clock, the data input and the active-low select as asynchronous. Each is passed through a synchronizer chain before the edges of the serial clock are classified. Per select frame it exchanges one byte: it shifts out a byte the system side supplied, and shifts in a byte that it hands back with a single-cycle strobe.

Three static controls set the format. Clock polarity gives the idle level of the serial clock. Clock phase sets which edge samples and which edge shifts. Bit order picks least or most significant bit first.

In phase-0 mode the first outgoing bit appears as soon as select falls. Select must be released between bytes in that mode: a ninth sampling edge inside one frame raises a framing error, and the extra data is discarded. In phase-1 mode select may stay low over several bytes.

Top module: `spi_frame_slave`

## Requirements
- R1: While reset is asserted, rx_byte is 0 and rx_valid, frame_err and miso_oe are 0.
- R2: sck, mosi and ss_n each pass through SYNC_STAGES flip-flops, so miso_oe cannot rise in the first system clock after ss_n falls. The serial clock may change level at most once every two system clocks, which makes its period at least four system clocks.
- R3: miso_oe is 1 while the synchronized ss_n is low and 0 while it is high.
- R4: tx_byte is captured when ss_n falls. In phase-0 mode (cfg_cpha=0), the first bit of that byte is on miso before any serial clock edge.
- R5: cfg_cpol sets the idle level of sck. The leading edge of a bit leaves that level and the trailing edge returns to it.
- R6: With cfg_cpha=0, mosi is sampled on leading edges and miso changes on trailing edges. With cfg_cpha=1, miso changes on leading edges (except the first of a byte) and mosi is sampled on trailing edges.
- R7: With cfg_lsb_first=1, bit 0 is sent and received first and bit 7 last. With cfg_lsb_first=0, the order is reversed.
- R8: After the eighth sampling edge of a byte, rx_byte holds the received byte and rx_valid is high for exactly one system clock.
- R9: With cfg_cpha=0, a sampling edge after the eighth one while ss_n stays low sets frame_err. That data is ignored: there is no rx_valid and rx_byte is unchanged. frame_err stays set until the next falling edge of ss_n clears it.
- R10: With cfg_cpha=1, ss_n may stay low across bytes. Each completed byte reloads tx_byte for the next one, and no frame_err is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first |
| tx_byte | input | DATA_W | Byte to send, captured at select fall |
| rx_byte | output | DATA_W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| frame_err | output | 1 | Extra bits seen in a phase-0 frame |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for miso |

## Verification
In phase-1 mode with select held low, completing a byte and reloading the transmit register for the next byte happen on the same sampling edge. The bench provokes this by sending two bytes in one frame, changing tx_byte after the first byte has been captured. It passes only if the second byte's bits on miso equal the new tx_byte and both received bytes are strobed in order. All eight polarity, phase and bit-order combinations are swept with several data patterns, and the master model computes each expected bit from its index.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
   localparam int SPI_MIN_SYNC = 2;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } spi_mode_t;
endpackage

// File: rtl/spi_fs_sync.sv
module spi_fs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < spi_fs_pkg::SPI_MIN_SYNC) begin : g_bad_stages
      $error("spi_fs_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_fs_edge.sv
module spi_fs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cpol,
   input  logic sel,
   output logic lead,
   output logic trail
);
   logic sck_d;
   logic moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   // leading edge leaves the idle level, trailing edge returns to it
   assign moved = sel & (sck_s ^ sck_d);
   assign lead  = moved & (sck_s != cpol);
   assign trail = moved & (sck_s == cpol);

   // R2: serial clock at most one quarter of the system clock
   a_r2_sck_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (lead || trail) |=> !(lead || trail));
endmodule

// File: rtl/spi_fs_shift.sv
module spi_fs_shift
   import spi_fs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spi_mode_t         mode,
   input  logic              sel,
   input  logic              ss_fall,
   input  logic              lead,
   input  logic              trail,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              frame_err,
   output logic              miso
);
   localparam int                CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DATA_W);

   logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
   logic [CNT_W-1:0]  cnt;
   logic              samp, drive, full;

   assign samp  = mode.cpha ? trail : lead;
   assign drive = mode.cpha ? lead  : trail;
   assign full  = (cnt == FULL);

   assign rx_next = mode.lsb_first ? {mosi_s, rx_sh[DATA_W-1:1]}
                                   : {rx_sh[DATA_W-2:0], mosi_s};
   assign miso    = mode.lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh     <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         rx_valid  <= 1'b0;
         frame_err <= 1'b0;
         cnt       <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (ss_fall) begin
            tx_sh     <= tx_byte;
            cnt       <= '0;
            frame_err <= 1'b0;
         end else if (sel) begin
            if (samp) begin
               if (full) begin
                  frame_err <= 1'b1;
               end else begin
                  rx_sh <= rx_next;
                  if (cnt == LAST) begin
                     rx_byte  <= rx_next;
                     rx_valid <= 1'b1;
                     if (mode.cpha) begin
                        cnt   <= '0;
                        tx_sh <= tx_byte;
                     end else begin
                        cnt <= FULL;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            if (drive && !full && cnt != '0) begin
               tx_sh <= mode.lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
            end
         end
      end
   end

   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !rx_valid);
   a_r10_err_phase0_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> !mode.cpha);
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
   import spi_fs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              frame_err,
   input  logic              sck,
   input  logic              mosi,
   input  logic              ss_n,
   output logic              miso,
   output logic              miso_oe
);
   if (DATA_W < 2) begin : g_bad_width
      $error("spi_frame_slave: DATA_W must be at least 2");
   end

   localparam int              N_IN   = 3;
   localparam logic [N_IN-1:0] IN_RST = 3'b100;   // select idles high

   logic [N_IN-1:0] raw_in, sync_in;
   logic            sck_s, mosi_s, ss_s, ss_d, sel, ss_fall, lead, trail;
   spi_mode_t       mode;

   assign raw_in = {ss_n, mosi, sck};

   for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
      spi_fs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IN_RST[gi])) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw_in[gi]), .q(sync_in[gi]));
   end

   assign sck_s  = sync_in[0];
   assign mosi_s = sync_in[1];
   assign ss_s   = sync_in[2];
   assign sel    = ~ss_s;
   assign mode   = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_d    <= 1'b1;
         miso_oe <= 1'b0;
      end else begin
         ss_d    <= ss_s;
         miso_oe <= sel;
      end
   end

   assign ss_fall = ss_d & ~ss_s;

   spi_fs_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(cfg_cpol), .sel(sel),
      .lead(lead), .trail(trail));

   spi_fs_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .ss_fall(ss_fall),
      .lead(lead), .trail(trail), .mosi_s(mosi_s), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_err(frame_err),
      .miso(miso));

   a_r3_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_s && ss_d) |=> !miso_oe);
endmodule

// File: tb/spi_frame_slave_test.sv
module spi_frame_slave_test;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_byte;
   logic       rx_valid, frame_err, miso, miso_oe;
   logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;

   int n_chk = 0, n_err = 0, vcnt = 0;
   logic [7:0] last_rx = 8'h00, prev_rx = 8'h00;

   always #4 clk = ~clk;   // 125 MHz

   spi_frame_slave uut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .tx_byte(tx_byte), .rx_byte(rx_byte),
      .rx_valid(rx_valid), .frame_err(frame_err), .sck(sck), .mosi(mosi),
      .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe));

   always @(posedge clk) begin
      if (rx_valid) begin
         vcnt    <= vcnt + 1;
         prev_rx <= last_rx;
         last_rx <= rx_byte;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_mode(input int m);
      cfg_cpol      = m[2];
      cfg_cpha      = m[1];
      cfg_lsb_first = m[0];
      sck           = m[2];
      wait_n(2 * HALF);
   endtask

   // master side: 8 bits, returns what was seen on miso
   task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
      mi = 8'h00;
      for (int i = 0; i < 8; i++) begin
         int idx;
         idx = cfg_lsb_first ? i : 7 - i;
         if (!cfg_cpha) begin
            mosi = mo[idx];
            wait_n(HALF);
            mi[idx] = miso;
            sck = ~cfg_cpol;
            wait_n(HALF);
            sck = cfg_cpol;
         end else begin
            sck = ~cfg_cpol;
            mosi = mo[idx];
            wait_n(HALF);
            mi[idx] = miso;
            sck = cfg_cpol;
            wait_n(HALF);
         end
      end
      wait_n(HALF);
   endtask

   task automatic frame(input logic [7:0] mo, input logic [7:0] tx);
      logic [7:0] mi;
      int v0;
      v0 = vcnt;
      tx_byte = tx;
      ss_n = 1'b0;
      wait_n(HALF);
      chk("R3 oe while selected", miso_oe, 1'b1);
      if (!cfg_cpha)
         chk("R4 first bit before clock", miso, cfg_lsb_first ? tx[0] : tx[7]);
      xfer(mo, mi);
      ss_n = 1'b1;
      wait_n(HALF);
      chk("R8 one strobe per byte", vcnt - v0, 1);
      chk("R6 R7 R5 received byte", last_rx, mo);
      chk("R6 R7 R5 sent byte", mi, tx);
      chk("R9 no error in clean frame", frame_err, 1'b0);
      chk("R3 oe off when deselected", miso_oe, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] pats [5];
      logic [7:0] m1, m2;
      int v0;
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

      wait_n(5);
      chk("R1 rx_byte reset", rx_byte, 8'h00);
      chk("R1 rx_valid reset", rx_valid, 1'b0);
      chk("R1 frame_err reset", frame_err, 1'b0);
      chk("R1 miso_oe reset", miso_oe, 1'b0);
      rst_n = 1'b1;
      wait_n(4);

      // R2: synchronizer latency on select
      ss_n = 1'b0;
      wait_n(1);
      chk("R2 oe not before sync", miso_oe, 1'b0);
      wait_n(5);
      chk("R2 oe after sync", miso_oe, 1'b1);
      ss_n = 1'b1;
      wait_n(HALF);
      chk("R3 oe drops on release", miso_oe, 1'b0);

      // sweep every polarity / phase / order combination
      for (int m = 0; m < 8; m++) begin
         set_mode(m);
         for (int p = 0; p < 5; p++)
            frame(pats[p] ^ 8'(m * 17), ~pats[p] + 8'(m));
      end

      // R9: second byte in one phase-0 frame
      set_mode(0);
      v0 = vcnt;
      tx_byte = 8'h5A;
      ss_n = 1'b0;
      wait_n(HALF);
      xfer(8'hA5, m1);
      xfer(8'h3C, m2);
      chk("R9 error raised", frame_err, 1'b1);
      chk("R9 extra byte not strobed", vcnt - v0, 1);
      chk("R9 rx_byte unchanged", rx_byte, 8'hA5);
      chk("R4 first byte still sent", m1, 8'h5A);
      ss_n = 1'b1;
      wait_n(HALF);
      chk("R9 error held after release", frame_err, 1'b1);
      ss_n = 1'b0;
      wait_n(HALF);
      chk("R9 error cleared by new frame", frame_err, 1'b0);
      ss_n = 1'b1;
      wait_n(2 * HALF);

      // R10: back-to-back bytes in phase-1 mode, reload coincides with strobe
      set_mode(2);
      v0 = vcnt;
      tx_byte = 8'h96;
      ss_n = 1'b0;
      wait_n(HALF);
      tx_byte = 8'h4E;
      xfer(8'hC3, m1);
      xfer(8'h17, m2);
      chk("R10 two strobes", vcnt - v0, 2);
      chk("R10 first rx", prev_rx, 8'hC3);
      chk("R10 second rx", last_rx, 8'h17);
      chk("R10 first tx", m1, 8'h96);
      chk("R10 reloaded tx", m2, 8'h4E);
      chk("R10 no error", frame_err, 1'b0);
      ss_n = 1'b1;
      wait_n(2 * HALF);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule